// File: doc/BRIEF.md
# Serial ID ROM Byte Reader

This block lets host software pull a globally unique identifier out of a two-wire serial EEPROM one byte at a time. Software sees a single 32-bit control/status word on a simple register bus. Two self-clearing command bits sit in that word. One rewinds an internal byte pointer to zero. The other fetches the byte under the pointer. A data field returns the fetched byte, and an offset field tells where an option-ROM image begins inside the EEPROM.

Each fetch runs a random-address read on the serial bus. The pointer then advances by one, so repeated fetches walk through the ROM in order. After reset, and before any software command runs, the block reads a fixed header location once to learn the option-ROM offset. An input strap says whether an ID ROM is fitted. While the strap is low, commands are refused.

Top module: `idrom_reader`

## Requirements
- R1: While reset is asserted and on the first register read after reset, the word reads all zero: both command bits, the data field (bits 23:16) and the offset field (bits 7:0) are 0, and the byte pointer is 0.
- R2: Writing 1 to bit 31 sets the pointer-rewind command. The bit reads 1 until the pointer is back at 0, then hardware clears it. The next fetch returns ROM byte 0. A rewind alone leaves the data field unchanged.
- R3: Writing 1 to bit 25 starts a fetch of the byte under the pointer. The bit reads 1 while the fetch is under way. When the fetch completes, hardware clears the bit and bits 23:16 hold the byte.
- R4: Each completed fetch advances the 8-bit pointer by one, wrapping from 255 to 0.
- R5: When one write sets both bits 31 and 25, the rewind is done first and the fetch then returns ROM byte 0.
- R6: While either command bit reads 1, writes to the register are ignored.
- R7: With the ID-ROM-present strap low, command writes are ignored, the register reads 0 and no serial activity takes place.
- R8: After reset with the strap high, the block fetches the byte at header address HDR_ADDR and reports it in bits 7:0. The field reads 0 until then.
- R9: Bits 30:26, bit 24 and bits 15:8 always read 0. The read data is 0 unless a read targets REG_ADDR. Writes to any other address have no effect. A write with both command bits 0 has no effect.
- R10: Each fetch on the serial bus runs in this order: START, device byte {DEV_ADDR,0} with ACK slot, word address equal to the pointer with ACK slot, repeated START, device byte {DEV_ADDR,1} with ACK slot, eight data bits MSB first sampled while SCL is high, the master leaving SDA released for NACK, and STOP. The SCL period is 4*CLK_DIV clock cycles.
- R11: While no transfer is running, SCL is driven high and SDA is released (sda_oe = 0).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rom_present | input | 1 | Strap: an ID ROM is fitted |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | ADDR_W | Register address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, 0 when not selected |
| scl_o | output | 1 | Serial clock to the EEPROM |
| sda_oe | output | 1 | 1 pulls the SDA line low |
| sda_i | input | 1 | Sensed level of the SDA line |

## Verification
The assertions assume that rom_present stays constant after reset and that sda_i reflects the wired-AND of this block's drive and the EEPROM's drive. The bench holds each strap fixed for the whole run, using a second instance for the strap-low case. It resolves the SDA line as the AND of both open-drain pulls. The checks also take for granted that the EEPROM changes SDA only while SCL is low. The bench's ROM model updates its drive only on SCL falling edges.

// File: rtl/idrom_pkg.sv
package idrom_pkg;

  localparam int ROM_AW = 8;
  localparam logic [5:0] SYM_LAST = 6'd38;

  typedef enum logic [2:0] {SK_START, SK_STOP, SK_TX, SK_RX, SK_REL} sym_kind_e;
  typedef enum logic [1:0] {CS_BOOT, CS_HDR, CS_IDLE, CS_READ} ctrl_st_e;

  // symbol map of one random read: 0 start, 1-8 dev wr, 9 ack, 10-17 word,
  // 18 ack, 19 restart, 20-27 dev rd, 28 ack, 29-36 data in, 37 nack, 38 stop
  function automatic sym_kind_e sym_kind(input logic [5:0] idx);
    if (idx == 6'd0 || idx == 6'd19) return SK_START;
    if (idx == SYM_LAST) return SK_STOP;
    if (idx == 6'd9 || idx == 6'd18 || idx == 6'd28 || idx == 6'd37) return SK_REL;
    if (idx >= 6'd29) return SK_RX;
    return SK_TX;
  endfunction

  function automatic logic tx_bit(input logic [5:0] idx, input logic [6:0] dev,
                                  input logic [ROM_AW-1:0] waddr);
    logic [7:0] b;
    int base;
    int p;
    if (idx <= 6'd8) begin
      b = {dev, 1'b0}; base = 1;
    end else if (idx <= 6'd17) begin
      b = waddr; base = 10;
    end else begin
      b = {dev, 1'b1}; base = 20;
    end
    p = 7 - (int'(idx) - base);
    if (p < 0 || p > 7) return 1'b1;
    return b[p[2:0]];
  endfunction

  function automatic logic sym_scl(input sym_kind_e k, input logic [1:0] q);
    if (k == SK_STOP) return q != 2'd0;
    return (q == 2'd1) || (q == 2'd2);
  endfunction

  function automatic logic sym_sda(input sym_kind_e k, input logic [1:0] q, input logic b);
    case (k)
      SK_START: return q <= 2'd1;
      SK_STOP:  return q >= 2'd2;
      SK_TX:    return b;
      default:  return 1'b1;
    endcase
  endfunction

  function automatic logic [31:0] pack_csr(input logic rw_rst, input logic rw_rd,
                                           input logic [7:0] data, input logic [7:0] off);
    return {rw_rst, 5'b0, rw_rd, 1'b0, data, 8'b0, off};
  endfunction

  function automatic logic cmd_accept(input logic hit, input logic present,
                                      input logic busy_rst, input logic busy_rd);
    return hit && present && !busy_rst && !busy_rd;
  endfunction

endpackage

// File: rtl/idrom_twi_engine.sv
module idrom_twi_engine
  import idrom_pkg::*;
#(
  parameter int CLK_DIV = 125,
  parameter logic [6:0] DEV_ADDR = 7'h50
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [ROM_AW-1:0] waddr,
  input  logic              sda_i,
  output logic              busy,
  output logic              done,
  output logic [7:0]        rdata,
  output logic              scl_o,
  output logic              sda_oe
);

  localparam int DIV_W = $clog2(CLK_DIV + 1);
  localparam logic [DIV_W-1:0] DIV_TOP = DIV_W'(CLK_DIV - 1);

  logic [DIV_W-1:0]  div_cnt;
  logic [1:0]        quarter;
  logic [5:0]        sym;
  logic              busy_q;
  logic [7:0]        shreg;
  logic [ROM_AW-1:0] waddr_q;
  logic              scl_q;
  logic              sda_q;

  // named internal events
  logic      tick;
  logic      sample_now;
  sym_kind_e kind;
  logic      bitv;

  assign tick       = busy_q && (div_cnt == DIV_TOP);
  assign kind       = sym_kind(sym);
  assign bitv       = tx_bit(sym, DEV_ADDR, waddr_q);
  assign sample_now = tick && (kind == SK_RX) && (quarter == 2'd2);
  assign done       = tick && (quarter == 2'd3) && (sym == SYM_LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_cnt <= '0;
      quarter <= 2'd0;
      sym     <= 6'd0;
      busy_q  <= 1'b0;
      shreg   <= 8'd0;
      waddr_q <= '0;
    end else if (!busy_q) begin
      if (start) begin
        busy_q  <= 1'b1;
        div_cnt <= '0;
        quarter <= 2'd0;
        sym     <= 6'd0;
        waddr_q <= waddr;
      end
    end else begin
      div_cnt <= tick ? '0 : div_cnt + 1'b1;
      if (sample_now) shreg <= {shreg[6:0], sda_i};
      if (tick) begin
        quarter <= quarter + 2'd1;
        if (quarter == 2'd3) begin
          if (sym == SYM_LAST) busy_q <= 1'b0;
          else                 sym    <= sym + 6'd1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= busy_q ? sym_scl(kind, quarter) : 1'b1;
      sda_q <= busy_q ? sym_sda(kind, quarter, bitv) : 1'b1;
    end
  end

  assign busy   = busy_q;
  assign rdata  = shreg;
  assign scl_o  = scl_q;
  assign sda_oe = ~sda_q;

  a_r11_idle_lines: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_q && !start) |=> (scl_q && sda_q));
  a_r10_done_ends: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !busy_q);
  a_r10_sym_bound: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |-> (sym <= SYM_LAST));
  a_r10_sample_high: assert property (@(posedge clk) disable iff (!rst_n)
    sample_now |-> scl_q);

endmodule

// File: rtl/idrom_cmd_ctrl.sv
module idrom_cmd_ctrl
  import idrom_pkg::*;
#(
  parameter logic [ROM_AW-1:0] HDR_ADDR = 8'hF0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rom_present,
  input  logic              wr_hit,
  input  logic              wr_rst,
  input  logic              wr_rd,
  input  logic              eng_busy,
  input  logic              eng_done,
  input  logic [7:0]        eng_data,
  output logic              eng_start,
  output logic [ROM_AW-1:0] eng_addr,
  output logic              cmd_rst,
  output logic              cmd_rd,
  output logic [7:0]        data_q,
  output logic [7:0]        offset_q
);

  ctrl_st_e          state;
  logic [ROM_AW-1:0] ptr;

  // named internal events
  logic accept;
  logic ptr_clr;
  logic rd_fin;
  logic hdr_fin;

  assign accept  = cmd_accept(wr_hit, rom_present, cmd_rst, cmd_rd);
  assign ptr_clr = (state == CS_IDLE) && cmd_rst;
  assign rd_fin  = (state == CS_READ) && eng_done;
  assign hdr_fin = (state == CS_HDR) && eng_done;

  assign eng_start = ((state == CS_BOOT) && rom_present) ||
                     ((state == CS_IDLE) && !cmd_rst && cmd_rd);
  assign eng_addr  = (state == CS_BOOT) ? HDR_ADDR : ptr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= CS_BOOT;
      cmd_rst  <= 1'b0;
      cmd_rd   <= 1'b0;
      ptr      <= '0;
      data_q   <= 8'd0;
      offset_q <= 8'd0;
    end else begin
      if (accept) begin
        cmd_rst <= wr_rst;
        cmd_rd  <= wr_rd;
      end
      case (state)
        CS_BOOT: state <= rom_present ? CS_HDR : CS_IDLE;
        CS_HDR: if (hdr_fin) begin
          offset_q <= eng_data;
          state    <= CS_IDLE;
        end
        CS_IDLE: begin
          if (ptr_clr) begin
            ptr     <= '0;
            cmd_rst <= 1'b0;
          end else if (cmd_rd) begin
            state <= CS_READ;
          end
        end
        CS_READ: if (rd_fin) begin
          data_q <= eng_data;
          ptr    <= ptr + 1'b1;
          cmd_rd <= 1'b0;
          state  <= CS_IDLE;
        end
        default: state <= CS_IDLE;
      endcase
    end
  end

  a_r3_rd_clears: assert property (@(posedge clk) disable iff (!rst_n)
    rd_fin |=> !cmd_rd);
  a_r3_rd_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_rd && !rd_fin) |=> cmd_rd);
  a_r2_ptr_cleared: assert property (@(posedge clk) disable iff (!rst_n)
    ptr_clr |=> ((ptr == '0) && !cmd_rst));
  a_r4_ptr_step: assert property (@(posedge clk) disable iff (!rst_n)
    rd_fin |=> (ptr == $past(ptr) + 1'b1));
  a_r5_rewind_first: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_rst && cmd_rd) |-> !eng_start);
  a_r6_no_set_when_busy: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cmd_rst) |-> !$past(cmd_rd));
  a_r7_strap_low: assert property (@(posedge clk) disable iff (!rst_n)
    !rom_present |-> (!cmd_rst && !cmd_rd));
  a_r10_start_when_free: assert property (@(posedge clk) disable iff (!rst_n)
    eng_start |-> !eng_busy);

endmodule

// File: rtl/idrom_reader.sv
module idrom_reader
  import idrom_pkg::*;
#(
  parameter int                ADDR_W   = 8,
  parameter logic [ADDR_W-1:0] REG_ADDR = 8'h04,
  parameter int                CLK_DIV  = 125,
  parameter logic [6:0]        DEV_ADDR = 7'h50,
  parameter logic [7:0]        HDR_ADDR = 8'hF0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rom_present,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              scl_o,
  output logic              sda_oe,
  input  logic              sda_i
);

  logic              sel;
  logic              wr_hit;
  logic              eng_start;
  logic              eng_busy;
  logic              eng_done;
  logic [7:0]        eng_data;
  logic [ROM_AW-1:0] eng_addr;
  logic              cmd_rst;
  logic              cmd_rd;
  logic [7:0]        data_q;
  logic [7:0]        offset_q;
  logic              unused_wbits;

  assign sel          = (bus_addr == REG_ADDR);
  assign wr_hit       = bus_wr && sel;
  assign unused_wbits = ^{bus_wdata[30:26], bus_wdata[24:0]};

  assign bus_rdata = (bus_rd && sel) ? pack_csr(cmd_rst, cmd_rd, data_q, offset_q) : 32'd0;

  idrom_cmd_ctrl #(.HDR_ADDR(HDR_ADDR)) u_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .rom_present (rom_present),
    .wr_hit      (wr_hit),
    .wr_rst      (bus_wdata[31]),
    .wr_rd       (bus_wdata[25]),
    .eng_busy    (eng_busy),
    .eng_done    (eng_done),
    .eng_data    (eng_data),
    .eng_start   (eng_start),
    .eng_addr    (eng_addr),
    .cmd_rst     (cmd_rst),
    .cmd_rd      (cmd_rd),
    .data_q      (data_q),
    .offset_q    (offset_q)
  );

  idrom_twi_engine #(.CLK_DIV(CLK_DIV), .DEV_ADDR(DEV_ADDR)) u_eng (
    .clk    (clk),
    .rst_n  (rst_n),
    .start  (eng_start),
    .waddr  (eng_addr),
    .sda_i  (sda_i),
    .busy   (eng_busy),
    .done   (eng_done),
    .rdata  (eng_data),
    .scl_o  (scl_o),
    .sda_oe (sda_oe)
  );

  a_r9_quiet_unselected: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_rd && sel) |-> (bus_rdata == 32'd0));

endmodule

// File: tb/tb_idrom_reader.sv
module tb_idrom_reader;

  localparam int         DIV  = 2;
  localparam logic [7:0] HDR  = 8'hF0;
  localparam logic [7:0] REGA = 8'h04;
  localparam logic [6:0] DEV  = 7'h50;

  // vector: {rewind, fetch, expected ROM address of the fetched byte}
  localparam logic [9:0] VEC [10] = '{
    {1'b1, 1'b1, 8'd0}, {1'b0, 1'b1, 8'd1}, {1'b0, 1'b1, 8'd2}, {1'b1, 1'b0, 8'd0},
    {1'b0, 1'b1, 8'd0}, {1'b0, 1'b1, 8'd1}, {1'b0, 1'b1, 8'd2}, {1'b0, 1'b1, 8'd3},
    {1'b1, 1'b1, 8'd0}, {1'b0, 1'b1, 8'd1}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0;
  logic        bus_rd = 1'b0;
  logic [7:0]  bus_addr = 8'd0;
  logic [31:0] bus_wdata = 32'd0;
  wire  [31:0] rdata;
  wire  [31:0] rdata_np;
  wire         scl;
  wire         sda_oe;
  wire         scl_np;
  wire         sda_oe_np;
  logic        slv_oe = 1'b0;
  wire         sda_line = ~(sda_oe | slv_oe);

  int checks = 0;
  int fails  = 0;

  always #10 clk = ~clk;

  idrom_reader #(.ADDR_W(8), .REG_ADDR(REGA), .CLK_DIV(DIV), .DEV_ADDR(DEV), .HDR_ADDR(HDR)) dut (
    .clk(clk), .rst_n(rst_n), .rom_present(1'b1), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(rdata),
    .scl_o(scl), .sda_oe(sda_oe), .sda_i(sda_line));

  idrom_reader #(.ADDR_W(8), .REG_ADDR(REGA), .CLK_DIV(DIV), .DEV_ADDR(DEV), .HDR_ADDR(HDR)) dut_np (
    .clk(clk), .rst_n(rst_n), .rom_present(1'b0), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(rdata_np),
    .scl_o(scl_np), .sda_oe(sda_oe_np), .sda_i(1'b1));

  function automatic logic [7:0] rom_byte(input logic [7:0] a);
    return (a * 8'd29) ^ 8'hC3;
  endfunction

  // ---------------- EEPROM model ----------------
  typedef enum int {M_IDLE, M_RX, M_ACK, M_TX} mstate_e;
  mstate_e     m_st = M_IDLE;
  int          m_cnt = 0;
  int          m_phase = 0;
  logic        m_rw = 1'b0;
  logic [7:0]  m_sh = 8'd0;
  logic [7:0]  m_ptr = 8'd0;
  logic [7:0]  m_tx = 8'd0;
  logic [7:0]  m_word = 8'd0;
  logic [7:0]  m_devw = 8'd0;
  logic [7:0]  m_devr = 8'd0;
  logic        p_scl = 1'b1;
  logic        p_sda = 1'b1;

  always @(scl, sda_line) begin
    if (scl && p_scl && p_sda && !sda_line) begin
      m_st = M_RX; m_cnt = 0; m_phase = 0; slv_oe = 1'b0;
    end else if (scl && !p_scl) begin
      if (m_st == M_RX) begin m_sh = {m_sh[6:0], sda_line}; m_cnt++; end
    end else if (!scl && p_scl) begin
      if (m_st == M_RX && m_cnt == 8) begin
        if (m_phase == 0) begin
          m_rw = m_sh[0];
          if (m_sh[0]) m_devr = m_sh; else begin m_devw = m_sh; m_phase = 1; end
        end else begin
          m_ptr = m_sh; m_word = m_sh; m_phase = 2;
        end
        slv_oe = 1'b1; m_st = M_ACK;
      end else if (m_st == M_ACK) begin
        m_cnt = 0;
        if (m_rw) begin
          m_st = M_TX; m_tx = rom_byte(m_ptr); slv_oe = ~m_tx[7];
        end else begin
          m_st = M_RX; slv_oe = 1'b0;
        end
      end else if (m_st == M_TX) begin
        m_cnt++;
        if (m_cnt < 8) slv_oe = ~m_tx[7 - m_cnt];
        else begin slv_oe = 1'b0; m_st = M_IDLE; m_ptr = m_ptr + 8'd1; end
      end
    end
    p_scl = scl;
    p_sda = sda_line;
  end

  // ---------------- line monitors ----------------
  int   cyc = 0;
  int   last_rise = 0;
  int   scl_period = 0;
  logic scl_prev = 1'b1;
  logic np_active = 1'b0;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (scl && !scl_prev) begin
      scl_period <= cyc - last_rise;
      last_rise  <= cyc;
    end
    scl_prev <= scl;
    if (rst_n && (!scl_np || sda_oe_np)) np_active <= 1'b1;
  end

  // ---------------- helpers ----------------
  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic rd_reg(output logic [31:0] v);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = REGA;
    #1 v = rdata;
    bus_rd = 1'b0;
  endtask

  task automatic rd_np(output logic [31:0] v);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = REGA;
    #1 v = rdata_np;
    bus_rd = 1'b0;
  endtask

  task automatic wr_reg(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0; bus_wdata = 32'd0;
  endtask

  task automatic wait_idle(input string req);
    logic [31:0] v;
    logic        ok;
    ok = 1'b0;
    for (int k = 0; k < 3000; k++) begin
      rd_reg(v);
      if (!v[31] && !v[25]) begin ok = 1'b1; break; end
    end
    check({req, " command bits self-clear"}, {31'd0, ok}, 32'd1);
  endtask

  task automatic fetch(output logic [31:0] v);
    wr_reg(REGA, 32'h0200_0000);
    wait_idle("R3");
    rd_reg(v);
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  // ---------------- main sequence ----------------
  initial begin
    logic [31:0] r;
    logic [7:0]  last;

    repeat (4) @(negedge clk);
    check("R11 scl high in reset", {31'd0, scl}, 32'd1);
    check("R11 sda released in reset", {31'd0, sda_oe}, 32'd0);
    rst_n = 1'b1;

    rd_reg(r);
    check("R1 R8 word after reset", r, 32'd0);

    repeat (400) @(negedge clk);
    rd_reg(r);
    check("R8 offset field", r, {24'd0, rom_byte(HDR)});
    check("R10 header word address", {24'd0, m_word}, {24'd0, HDR});

    last = 8'd0;
    for (int i = 0; i < 10; i++) begin
      wr_reg(REGA, {VEC[i][9], 5'd0, VEC[i][8], 25'd0});
      if (VEC[i][8]) begin
        rd_reg(r);
        check("R3 fetch bit live", {31'd0, r[25]}, 32'd1);
      end
      wait_idle("R2 R3");
      rd_reg(r);
      if (VEC[i][8]) begin
        last = rom_byte(VEC[i][7:0]);
        check("R3 R4 R5 fetched byte", {24'd0, r[23:16]}, {24'd0, last});
        check("R10 word address sent", {24'd0, m_word}, {24'd0, VEC[i][7:0]});
      end else begin
        check("R2 rewind keeps data", {24'd0, r[23:16]}, {24'd0, last});
      end
      check("R9 reserved bits", r & 32'h7D00_FF00, 32'd0);
    end

    // R6: rewind while a fetch runs is refused
    wr_reg(REGA, 32'h0200_0000);
    wr_reg(REGA, 32'h8000_0000);
    rd_reg(r);
    check("R6 rewind refused while busy", {30'd0, r[31], r[25]}, 32'd1);
    wait_idle("R6");
    rd_reg(r);
    check("R6 fetch in flight byte", {24'd0, r[23:16]}, {24'd0, rom_byte(8'd2)});
    fetch(r);
    check("R6 pointer not rewound", {24'd0, r[23:16]}, {24'd0, rom_byte(8'd3)});

    // R9: zero write and wrong-address write change nothing
    wr_reg(REGA, 32'd0);
    rd_reg(r);
    check("R9 zero write no effect", r, {8'd0, rom_byte(8'd3), 8'd0, rom_byte(HDR)});
    wr_reg(REGA + 8'd4, 32'h8200_0000);
    rd_reg(r);
    check("R9 other address write ignored", r, {8'd0, rom_byte(8'd3), 8'd0, rom_byte(HDR)});
    fetch(r);
    check("R9 pointer kept after ignored writes", {24'd0, r[23:16]}, {24'd0, rom_byte(8'd4)});
    @(negedge clk);
    bus_addr = REGA; bus_rd = 1'b0;
    #1 check("R9 rdata zero without read", rdata, 32'd0);

    check("R10 device write byte", {24'd0, m_devw}, {24'd0, DEV, 1'b0});
    check("R10 device read byte", {24'd0, m_devr}, {24'd0, DEV, 1'b1});
    check("R10 scl period", scl_period, 4 * DIV);
    repeat (4) @(negedge clk);
    check("R11 idle lines", {30'd0, scl, sda_oe}, 32'd2);

    // R4: full walk and wrap
    wr_reg(REGA, 32'h8000_0000);
    wait_idle("R2");
    for (int i = 0; i < 257; i++) begin
      fetch(r);
      check("R4 sequential byte", {24'd0, r[23:16]}, {24'd0, rom_byte(8'(i))});
    end

    // R7: strap-low instance
    rd_np(r);
    check("R7 strap low reads zero", r, 32'd0);
    check("R7 strap low bus quiet", {31'd0, np_active}, 32'd0);

    finish_run();
  end

endmodule